// File: doc/BRIEF.md
# Three-Layer Palettized Pixel Compositor

This block merges three pixel candidates for each screen position: one from the background tile layer, one from the sprite layer and one from the text layer. Each candidate comes in as a palette number, a color index and a valid flag. A sprite candidate also carries a bit that places it either in front of or behind the background. The block applies three layer-disable bits from a control word and picks the winning layer. It then forms the word address of that layer's color in palette RAM and issues the read.

The palette RAM sits outside the block and answers one cycle after the read. The block registers the returned 15-bit RGB word so that it lines up with a valid strobe. The result appears exactly two cycles after the pixel was presented. Pixels can stream one per cycle.

Top module: `pix_compositor`

## Requirements
- R1: `out_valid` is asserted exactly two clock cycles after `in_valid` was sampled high, and is low two cycles after it was sampled low. `pram_rd_en` follows `in_valid` combinationally, so one pixel per cycle is accepted.
- R2: An opaque text pixel wins over sprite and background. Its palette word address is 0x800 + palette*16 + index.
- R3: A text color index of 15 is transparent, so the next layer shows through.
- R4: A background color index of 31 is transparent. An opaque background pixel reads word 0x400 + palette*32 + index.
- R5: A sprite with priority bit 0 is drawn over an opaque background, and one with priority bit 1 is drawn under it. A sprite reads word palette*32 + index. Sprite opacity comes only from its valid flag, so index 31 is opaque.
- R6: Control bit 11 (0x0800) set removes the text layer from the merge.
- R7: Control bit 12 (0x1000) set removes the background layer from the merge.
- R8: Control bit 13 (0x2000) set removes only sprites with priority bit 0. Sprites with priority bit 1 are still drawn.
- R9: When no layer is opaque, `out_rgb` is 0 while `out_valid` is high, whatever the palette RAM returns.
- R10: `out_rgb` equals bits 14:0 of the palette word read for the winning layer. Bit 15 of that word is ignored.
- R11: While `rst` is high at a clock edge, `out_valid` and `out_rgb` are cleared on that edge, even with pixels in flight.
- R12: While `out_valid` is low, `out_rgb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 16 | Control word; bit 11 text off, bit 12 background off, bit 13 front sprites off |
| in_valid | input | 1 | A pixel is presented this cycle |
| bg_vld | input | 1 | Background candidate present |
| bg_pal | input | 5 | Background palette number |
| bg_idx | input | 5 | Background color index (31 transparent) |
| spr_vld | input | 1 | Sprite candidate present and opaque |
| spr_pal | input | 5 | Sprite palette number |
| spr_idx | input | 5 | Sprite color index |
| spr_behind | input | 1 | 1: sprite under background, 0: over |
| txt_vld | input | 1 | Text candidate present |
| txt_pal | input | 5 | Text palette number |
| txt_idx | input | 4 | Text color index (15 transparent) |
| pram_rd_en | output | 1 | Palette RAM read enable |
| pram_addr | output | 12 | Palette RAM word address |
| pram_rd_data | input | 16 | Palette RAM read data, one cycle after the read |
| out_valid | output | 1 | Output pixel strobe |
| out_rgb | output | 15 | Red 14:10, green 9:5, blue 4:0 |

## Verification
A new pixel's layer choice and palette address are formed in the same cycle that the previous pixel's palette word comes back and is registered. Pixels from different layers, some with no opaque layer at all, are therefore driven back to back with no idle gap. Each output is compared two cycles later against a value computed from an address-keyed palette model. Every model word has bit 15 set, so a late, early or mixed-up pixel, or a leaked bit 15, shows up as a wrong RGB value.

// File: rtl/pixmix_pkg.sv
package pixmix_pkg;
  typedef enum logic [1:0] {
    LYR_NONE = 2'd0,
    LYR_SPR  = 2'd1,
    LYR_BG   = 2'd2,
    LYR_TXT  = 2'd3
  } layer_e;
endpackage

// File: rtl/pixmix_opacity.sv
module pixmix_opacity #(
  parameter int IDX_W     = 5,
  parameter bit HAS_HOLE  = 1'b1
) (
  input  logic             vld,
  input  logic             enable,
  input  logic [IDX_W-1:0] idx,
  output logic             opaque
);
  localparam logic [IDX_W-1:0] HOLE_IDX = {IDX_W{1'b1}};

  generate
    if (HAS_HOLE) begin : g_hole
      assign opaque = vld && enable && (idx != HOLE_IDX);
    end else begin : g_flag_only
      logic unused_idx;
      assign unused_idx = ^idx;
      assign opaque = vld && enable;
    end
  endgenerate
endmodule

// File: rtl/pixmix_arbiter.sv
module pixmix_arbiter
  import pixmix_pkg::*;
(
  input  logic   txt_op,
  input  logic   spr_front_op,
  input  logic   bg_op,
  input  logic   spr_back_op,
  output layer_e win
);
  always_comb begin
    if (txt_op)            win = LYR_TXT;
    else if (spr_front_op) win = LYR_SPR;
    else if (bg_op)        win = LYR_BG;
    else if (spr_back_op)  win = LYR_SPR;
    else                   win = LYR_NONE;
  end
endmodule

// File: rtl/pixmix_addr_gen.sv
module pixmix_addr_gen
  import pixmix_pkg::*;
#(
  parameter int PAL_W  = 5,
  parameter int IDX_W  = 5,
  parameter int TIDX_W = 4,
  parameter int ADDR_W = PAL_W + IDX_W + 2
) (
  input  layer_e              win,
  input  logic [PAL_W-1:0]    spr_pal,
  input  logic [IDX_W-1:0]    spr_idx,
  input  logic [PAL_W-1:0]    bg_pal,
  input  logic [IDX_W-1:0]    bg_idx,
  input  logic [PAL_W-1:0]    txt_pal,
  input  logic [TIDX_W-1:0]   txt_idx,
  output logic [ADDR_W-1:0]   addr
);
  localparam int PAD_W = IDX_W - TIDX_W;

  logic [ADDR_W-1:0] spr_a, bg_a, txt_a;
  assign spr_a = {2'b00, spr_pal, spr_idx};
  assign bg_a  = {2'b01, bg_pal, bg_idx};
  assign txt_a = {2'b10, {PAD_W{1'b0}}, txt_pal, txt_idx};

  always_comb begin
    unique case (win)
      LYR_SPR: addr = spr_a;
      LYR_BG:  addr = bg_a;
      LYR_TXT: addr = txt_a;
      default: addr = '0;
    endcase
  end
endmodule

// File: rtl/pixmix_out_stage.sv
module pixmix_out_stage #(
  parameter int RGB_W = 15
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pix_valid,
  input  logic           pix_none,
  input  logic [RGB_W:0] rd_data,
  output logic           out_valid,
  output logic [RGB_W-1:0] out_rgb
);
  logic v1, none1;
  logic unused_msb;
  assign unused_msb = rd_data[RGB_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      v1    <= 1'b0;
      none1 <= 1'b0;
    end else begin
      v1    <= pix_valid;
      none1 <= pix_none;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= v1;
      out_rgb   <= (v1 && !none1) ? rd_data[RGB_W-1:0] : '0;
    end
  end

  // R12: idle output carries no color
  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_rgb == '0);
endmodule

// File: rtl/pix_compositor.sv
module pix_compositor
  import pixmix_pkg::*;
#(
  parameter int PAL_W       = 5,
  parameter int IDX_W       = 5,
  parameter int TIDX_W      = 4,
  parameter int RGB_W       = 15,
  parameter int CTRL_W      = 16,
  parameter int DIS_TXT_BIT = 11,
  parameter int DIS_BG_BIT  = 12,
  parameter int DIS_HI_BIT  = 13,
  parameter int ADDR_W      = PAL_W + IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              in_valid,
  input  logic              bg_vld,
  input  logic [PAL_W-1:0]  bg_pal,
  input  logic [IDX_W-1:0]  bg_idx,
  input  logic              spr_vld,
  input  logic [PAL_W-1:0]  spr_pal,
  input  logic [IDX_W-1:0]  spr_idx,
  input  logic              spr_behind,
  input  logic              txt_vld,
  input  logic [PAL_W-1:0]  txt_pal,
  input  logic [TIDX_W-1:0] txt_idx,
  output logic              pram_rd_en,
  output logic [ADDR_W-1:0] pram_addr,
  input  logic [RGB_W:0]    pram_rd_data,
  output logic              out_valid,
  output logic [RGB_W-1:0]  out_rgb
);
  logic dis_txt, dis_bg, dis_hi;
  assign dis_txt = ctrl_word[DIS_TXT_BIT];
  assign dis_bg  = ctrl_word[DIS_BG_BIT];
  assign dis_hi  = ctrl_word[DIS_HI_BIT];

  logic unused_ctrl;
  assign unused_ctrl = ^ctrl_word;

  logic txt_op, bg_op, spr_op;

  pixmix_opacity #(.IDX_W(TIDX_W), .HAS_HOLE(1'b1)) u_txt_op (
    .vld(txt_vld), .enable(!dis_txt), .idx(txt_idx), .opaque(txt_op));
  pixmix_opacity #(.IDX_W(IDX_W), .HAS_HOLE(1'b1)) u_bg_op (
    .vld(bg_vld), .enable(!dis_bg), .idx(bg_idx), .opaque(bg_op));
  pixmix_opacity #(.IDX_W(IDX_W), .HAS_HOLE(1'b0)) u_spr_op (
    .vld(spr_vld), .enable(1'b1), .idx(spr_idx), .opaque(spr_op));

  logic spr_front_op, spr_back_op;
  assign spr_front_op = spr_op && !spr_behind && !dis_hi;
  assign spr_back_op  = spr_op && spr_behind;

  layer_e win;
  pixmix_arbiter u_arb (
    .txt_op(txt_op), .spr_front_op(spr_front_op), .bg_op(bg_op),
    .spr_back_op(spr_back_op), .win(win));

  pixmix_addr_gen #(.PAL_W(PAL_W), .IDX_W(IDX_W), .TIDX_W(TIDX_W), .ADDR_W(ADDR_W)) u_addr (
    .win(win), .spr_pal(spr_pal), .spr_idx(spr_idx), .bg_pal(bg_pal), .bg_idx(bg_idx),
    .txt_pal(txt_pal), .txt_idx(txt_idx), .addr(pram_addr));

  assign pram_rd_en = in_valid;

  pixmix_out_stage #(.RGB_W(RGB_W)) u_out (
    .clk(clk), .rst(rst), .pix_valid(in_valid), .pix_none(win == LYR_NONE),
    .rd_data(pram_rd_data), .out_valid(out_valid), .out_rgb(out_rgb));

  // cycles since reset, saturating, for the latency check
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    warm == 2'd2 |-> out_valid == $past(in_valid, 2));

  assert_txt_region_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && txt_vld && txt_idx != {TIDX_W{1'b1}} && !ctrl_word[DIS_TXT_BIT])
      |-> pram_addr[ADDR_W-1 -: 2] == 2'b10);

  assert_txt_off_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ctrl_word[DIS_TXT_BIT]) |-> pram_addr[ADDR_W-1 -: 2] != 2'b10);

  assert_bg_off_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ctrl_word[DIS_BG_BIT]) |-> pram_addr[ADDR_W-1 -: 2] != 2'b01);
endmodule

// File: tb/tb_pix_compositor.sv
module tb_pix_compositor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ctrl_word = '0;
  logic        in_valid = 1'b0;
  logic        bg_vld = 1'b0, spr_vld = 1'b0, txt_vld = 1'b0, spr_behind = 1'b0;
  logic [4:0]  bg_pal = '0, bg_idx = '0, spr_pal = '0, spr_idx = '0, txt_pal = '0;
  logic [3:0]  txt_idx = '0;
  logic        pram_rd_en;
  logic [11:0] pram_addr;
  logic [15:0] pram_rd_data;
  logic        out_valid;
  logic [14:0] out_rgb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pix_compositor dut (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .in_valid(in_valid),
    .bg_vld(bg_vld), .bg_pal(bg_pal), .bg_idx(bg_idx),
    .spr_vld(spr_vld), .spr_pal(spr_pal), .spr_idx(spr_idx), .spr_behind(spr_behind),
    .txt_vld(txt_vld), .txt_pal(txt_pal), .txt_idx(txt_idx),
    .pram_rd_en(pram_rd_en), .pram_addr(pram_addr), .pram_rd_data(pram_rd_data),
    .out_valid(out_valid), .out_rgb(out_rgb));

  // palette model: distinct word per address, bit 15 always set
  function automatic logic [15:0] pmodel(input logic [11:0] a);
    logic [15:0] t;
    t = {4'b0, a} * 16'd7 + 16'h0123;
    return 16'h8000 | (t & 16'h7fff);
  endfunction

  always_ff @(posedge clk) begin
    if (pram_rd_en) pram_rd_data <= pmodel(pram_addr);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  dis;   // {front sprites, background, text}
    logic        bgv;
    logic [4:0]  bgp;
    logic [4:0]  bgi;
    logic        sv;
    logic [4:0]  sp;
    logic [4:0]  si;
    logic        sb;
    logic        tv;
    logic [4:0]  tp;
    logic [3:0]  ti;
    logic        none;
    logic [11:0] addr;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    // 0 R9: nothing present
    '{3'b000, 1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 4'd0, 1'b1, 12'h000},
    // 1 R2: text over front sprite and background
    '{3'b000, 1'b1, 5'd4, 5'd9, 1'b1, 5'd2, 5'd7, 1'b0, 1'b1, 5'd3, 4'd5, 1'b0, 12'h835},
    // 2 R3/R5: transparent text, front sprite over background
    '{3'b000, 1'b1, 5'd4, 5'd9, 1'b1, 5'd2, 5'd7, 1'b0, 1'b1, 5'd3, 4'd15, 1'b0, 12'h047},
    // 3 R4/R5: sprite behind opaque background
    '{3'b000, 1'b1, 5'd4, 5'd9, 1'b1, 5'd2, 5'd7, 1'b1, 1'b0, 5'd0, 4'd0, 1'b0, 12'h489},
    // 4 R4/R5: background hole shows behind sprite, sprite index 31 opaque
    '{3'b000, 1'b1, 5'd4, 5'd31, 1'b1, 5'd1, 5'd31, 1'b1, 1'b0, 5'd0, 4'd0, 1'b0, 12'h03F},
    // 5 R9: only a transparent background
    '{3'b000, 1'b1, 5'd7, 5'd31, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 4'd0, 1'b1, 12'h000},
    // 6 R6: text disabled
    '{3'b001, 1'b1, 5'd0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b1, 5'd3, 4'd5, 1'b0, 12'h400},
    // 7 R7: background disabled, rear sprite shows
    '{3'b010, 1'b1, 5'd4, 5'd9, 1'b1, 5'd31, 5'd0, 1'b1, 1'b0, 5'd0, 4'd0, 1'b0, 12'h3E0},
    // 8 R8: front sprite disabled, background shows
    '{3'b100, 1'b1, 5'd6, 5'd2, 1'b1, 5'd5, 5'd1, 1'b0, 1'b0, 5'd0, 4'd0, 1'b0, 12'h4C2},
    // 9 R8: rear sprite survives the front-sprite disable
    '{3'b100, 1'b1, 5'd6, 5'd31, 1'b1, 5'd5, 5'd1, 1'b1, 1'b0, 5'd0, 4'd0, 1'b0, 12'h0A1},
    // 10 R8: front sprite disabled, nothing else
    '{3'b100, 1'b0, 5'd0, 5'd0, 1'b1, 5'd5, 5'd1, 1'b0, 1'b0, 5'd0, 4'd0, 1'b1, 12'h000},
    // 11 R6/R7/R8: every layer disabled
    '{3'b111, 1'b1, 5'd4, 5'd9, 1'b1, 5'd2, 5'd7, 1'b0, 1'b1, 5'd3, 4'd5, 1'b1, 12'h000},
    // 12 R2: top text palette
    '{3'b000, 1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b1, 5'd31, 4'd14, 1'b0, 12'h9FE},
    // 13 R4: top background palette
    '{3'b000, 1'b1, 5'd31, 5'd30, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 4'd0, 1'b0, 12'h7FE}
  };

  function automatic string vtag(input int i);
    case (i)
      0, 5:     return "R9";
      1, 12:    return "R2";
      2:        return "R3";
      3, 4, 13: return "R4";
      6:        return "R6";
      7:        return "R7";
      8, 9, 10: return "R8";
      default:  return "R6_R7_R8";
    endcase
  endfunction

  task automatic drive(input vec_t v);
    in_valid   = 1'b1;
    ctrl_word  = {2'b00, v.dis, 11'b0};
    bg_vld = v.bgv; bg_pal = v.bgp; bg_idx = v.bgi;
    spr_vld = v.sv; spr_pal = v.sp; spr_idx = v.si; spr_behind = v.sb;
    txt_vld = v.tv; txt_pal = v.tp; txt_idx = v.ti;
  endtask

  function automatic logic [14:0] exp_rgb(input vec_t v);
    return v.none ? 15'd0 : pmodel(v.addr)[14:0];
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset out_valid", {31'b0, out_valid}, 32'd0);
    check("R11 reset out_rgb", {17'b0, out_rgb}, 32'd0);
    rst = 1'b0;

    // streaming table: output of pixel i-2 judged while pixel i is arbitrated
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check({vtag(i-2), " valid"}, {31'b0, out_valid}, 32'd1);
        check({vtag(i-2), " rgb R10"}, {17'b0, out_rgb}, {17'b0, exp_rgb(VECS[i-2])});
      end
      if (i < NV) begin
        drive(VECS[i]);
        #1;
        check("R1 rd_en", {31'b0, pram_rd_en}, 32'd1);
        if (!VECS[i].none)
          check({vtag(i), " addr"}, {20'b0, pram_addr}, {20'b0, VECS[i].addr});
      end else begin
        in_valid = 1'b0;
      end
    end

    // R1: single pixel latency, and R12 idle output before it
    repeat (3) @(negedge clk);
    drive(VECS[1]);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 not yet", {31'b0, out_valid}, 32'd0);
    check("R12 idle rgb", {17'b0, out_rgb}, 32'd0);
    @(negedge clk);
    check("R1 on time", {31'b0, out_valid}, 32'd1);
    check("R2 rgb", {17'b0, out_rgb}, {17'b0, exp_rgb(VECS[1])});
    @(negedge clk);
    check("R1 single strobe", {31'b0, out_valid}, 32'd0);

    // R12: candidates present but no pixel strobe
    drive(VECS[1]);
    in_valid = 1'b0;
    #1;
    check("R1 no read when idle", {31'b0, pram_rd_en}, 32'd0);
    repeat (2) @(negedge clk);
    check("R12 idle valid", {31'b0, out_valid}, 32'd0);
    check("R12 idle rgb", {17'b0, out_rgb}, 32'd0);

    // R11: reset with a pixel in flight
    drive(VECS[12]);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R11 flush valid", {31'b0, out_valid}, 32'd0);
    check("R11 flush rgb", {17'b0, out_rgb}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 stays clear", {31'b0, out_valid}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule